// File: doc/BRIEF.md
# Multiphase Mesochronous Phase-Select Synchronizer

This block moves a bundle of parallel data lanes into the local clock domain of a mesochronous system. The far end sends the lanes together with one reference lane. Every local clock cycle the block receives a vector of NPH samples for the reference lane and for each data lane. The samples are taken at NPH equally spaced phases of the local clock, so bit p of a vector is the sample taken at phase p.

A shared detector looks for a rising transition in the reference samples. A controller keeps one selected phase for the whole bundle and steers it toward the point about half a period away from that transition. It moves only after the same direction has been requested repeatedly, and never by more than one step at a time. The selected phase keeps following slow wander after start-up, with no separate initialization sequence.

One bit per lane is forwarded one cycle after its samples arrive. A wrap of the selection from the last phase to phase 0 loses one bit, and the output flags that cycle. A wrap from phase 0 to the last phase samples one bit twice, and the output flags the repeat and marks it not valid.

Top module: `mesosync_phase_select`

## Requirements
- R1: While `rst` is high, and on the first output after it, `phase_sel` is 0 and `data_out`, `data_vld`, `slip_drop`, `slip_dup` and `locked` are all 0.
- R2: After each rising clock edge, `data_out[l]` equals bit `l*NPH + phase_sel` of the `lane_smp` value that was present before that edge, using the `phase_sel` value held during that cycle. `data_vld` is 1 unless R8 applies.
- R3: The reference index is the lowest i for which `ref_smp[i]` is 0 and `ref_smp[(i+1) mod NPH]` is 1. The target phase is (i + ceil(NPH/2)) mod NPH. Let d = (target − phase_sel) mod NPH. The request is none when d = 0, forward (+1) when 1 ≤ d ≤ floor(NPH/2), and backward (−1) otherwise. Any reference vector with a transition is accepted, whatever its pattern.
- R4: The selection moves only when the same non-none request arrives on `hyst_len` consecutive transition-bearing cycles. A different request, or a none request, restarts the count, and the count restarts after each move. A `hyst_len` of 0 behaves as 1.
- R5: `phase_sel` changes by at most one phase step (modulo NPH) per clock cycle.
- R6: A cycle whose `ref_smp` holds no rising transition (all zeros or all ones) changes neither `phase_sel`, the hysteresis count, nor `locked`.
- R7: A forward move from phase NPH−1 to phase 0 sets `slip_drop` for exactly one cycle, together with the first output bit sampled at the new phase, and `data_vld` stays 1.
- R8: A backward move from phase 0 to phase NPH−1 sets `slip_dup` for exactly one cycle, together with the first output bit sampled at the new phase, and `data_vld` is 0 in that cycle.
- R9: `locked` rises once `hyst_len` consecutive transition-bearing cycles each see a target within one circular step of the selected phase. The first transition-bearing cycle with a larger distance clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous active-high reset |
| hyst_len | input | HW | Consecutive equal requests needed before a move; 0 acts as 1 |
| ref_smp | input | NPH | Reference lane samples, bit p taken at phase p |
| lane_smp | input | LANES*NPH | Data lane samples, lane l in bits l*NPH +: NPH |
| data_out | output | LANES | One synchronized bit per lane |
| data_vld | output | 1 | Output bits are a new word |
| slip_drop | output | 1 | One bit was lost before this word |
| slip_dup | output | 1 | This word repeats the previous one |
| locked | output | 1 | Selection agrees with the target |
| phase_sel | output | $clog2(NPH) | Currently selected sampling phase |

## Verification
The assertions assume that `rst` is held for at least one clock edge before checking starts, and that `hyst_len` stays constant between resets, so the hysteresis and lock counts always refer to a single threshold. The stimulus changes `ref_smp`, `lane_smp` and `hyst_len` only at falling edges, and it changes `hyst_len` only while reset is asserted. Reference vectors with a single rising edge place the target at every phase. Multi-edge and non-alternating vectors check that the lowest rising index wins.

// File: rtl/ps_pkg.sv
package ps_pkg;

  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_FWD  = 2'd1,
    STEP_BWD  = 2'd2
  } step_t;

endpackage

// File: rtl/ps_ref_edge.sv
// Shared reference-lane edge finder: lowest index with a 0 -> 1 step,
// wrapping from the last phase back to phase 0.
module ps_ref_edge #(
  parameter  int NPH = 5,
  localparam int PW  = $clog2(NPH)
) (
  input  logic [NPH-1:0] ref_smp,
  output logic           found,
  output logic [PW-1:0]  idx
);

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NPH - 1; i >= 0; i--) begin
      if (!ref_smp[i] && ref_smp[(i + 1) % NPH]) begin
        found = 1'b1;
        idx   = PW'(i);
      end
    end
  end

endmodule

// File: rtl/ps_phase_ctrl.sv
// Phase selection controller: target computation, hysteresis,
// single-step movement with wrap reporting, and lock tracking.
module ps_phase_ctrl
  import ps_pkg::*;
#(
  parameter  int NPH = 5,
  parameter  int HW  = 4,
  localparam int PW  = $clog2(NPH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [HW-1:0] hyst_len,
  input  logic          found,
  input  logic [PW-1:0] idx,
  output logic [PW-1:0] sel,
  output logic          wrap_drop,
  output logic          wrap_dup,
  output logic          locked
);

  localparam int            OFF    = (NPH + 1) / 2;
  localparam int            HALF   = NPH / 2;
  localparam logic [PW:0]   NPH_W  = (PW + 1)'(NPH);
  localparam logic [PW:0]   OFF_W  = (PW + 1)'(OFF);
  localparam logic [PW:0]   HALF_W = (PW + 1)'(HALF);
  localparam logic [PW-1:0] LAST   = PW'(NPH - 1);

  logic [PW:0]   tsum;
  logic [PW-1:0] tgt;
  logic [PW:0]   dfw;
  logic          near;
  step_t         req;
  step_t         last_req;
  logic [HW-1:0] cnt;
  logic [HW:0]   hyst_eff;
  logic [HW:0]   cnt_nxt;
  logic          go;
  logic [PW-1:0] sel_fwd;
  logic [PW-1:0] sel_bwd;
  logic [HW-1:0] lock_cnt;
  logic [HW-1:0] lock_inc;

  // target phase: about half a period away from the reference edge
  always_comb begin
    tsum = {1'b0, idx} + OFF_W;
    tgt  = (tsum >= NPH_W) ? PW'(tsum - NPH_W) : PW'(tsum);
    dfw  = (tgt >= sel) ? ({1'b0, tgt} - {1'b0, sel})
                        : ({1'b0, tgt} + NPH_W - {1'b0, sel});
    near = (dfw <= (PW + 1)'(1)) || (dfw >= NPH_W - (PW + 1)'(1));
    if (dfw == '0)          req = STEP_NONE;
    else if (dfw <= HALF_W) req = STEP_FWD;
    else                    req = STEP_BWD;
  end

  // hysteresis
  always_comb begin
    hyst_eff = (hyst_len == '0) ? (HW + 1)'(1) : {1'b0, hyst_len};
    cnt_nxt  = (req == last_req) ? ({1'b0, cnt} + (HW + 1)'(1)) : (HW + 1)'(1);
    go       = found && (req != STEP_NONE) && (cnt_nxt >= hyst_eff);
    sel_fwd  = (sel == LAST) ? '0 : sel + PW'(1);
    sel_bwd  = (sel == '0) ? LAST : sel - PW'(1);
    lock_inc = (lock_cnt == '1) ? lock_cnt : lock_cnt + HW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel       <= '0;
      cnt       <= '0;
      last_req  <= STEP_NONE;
      wrap_drop <= 1'b0;
      wrap_dup  <= 1'b0;
      lock_cnt  <= '0;
      locked    <= 1'b0;
    end else begin
      wrap_drop <= 1'b0;
      wrap_dup  <= 1'b0;
      if (found) begin
        last_req <= req;
        if (req == STEP_NONE) begin
          cnt <= '0;
        end else if (go) begin
          cnt <= '0;
          if (req == STEP_FWD) begin
            sel       <= sel_fwd;
            wrap_drop <= (sel == LAST);
          end else begin
            sel      <= sel_bwd;
            wrap_dup <= (sel == '0);
          end
        end else begin
          cnt <= cnt_nxt[HW-1:0];
        end
        if (near) begin
          lock_cnt <= lock_inc;
          locked   <= ({1'b0, lock_inc} >= hyst_eff);
        end else begin
          lock_cnt <= '0;
          locked   <= 1'b0;
        end
      end
    end
  end

  // R5: one phase step at most per cycle
  a_r5_one_step: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((sel == $past(sel)) ||
              (sel == (($past(sel) == LAST) ? '0 : $past(sel) + PW'(1))) ||
              (sel == (($past(sel) == '0) ? LAST : $past(sel) - PW'(1)))));

  // R6: no reference transition, no movement
  a_r6_quiet_hold: assert property (@(posedge clk) disable iff (rst)
    !found |=> $stable(sel) && $stable(locked));

  // R7 / R8: the two wrap kinds never coincide
  a_r7_r8_wrap_excl: assert property (@(posedge clk) disable iff (rst)
    !(wrap_drop && wrap_dup));

endmodule

// File: rtl/ps_lane_pick.sv
// Per-lane registered phase selection.
module ps_lane_pick #(
  parameter  int NPH   = 5,
  parameter  int LANES = 4,
  localparam int PW    = $clog2(NPH)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [LANES*NPH-1:0] lane_smp,
  input  logic [PW-1:0]        sel,
  output logic [LANES-1:0]     bits_q
);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [NPH-1:0] vec;
    logic           bit_q;
    assign vec = lane_smp[l*NPH +: NPH];
    always_ff @(posedge clk) begin
      if (rst) bit_q <= 1'b0;
      else     bit_q <= vec[sel];
    end
    assign bits_q[l] = bit_q;
  end

endmodule

// File: rtl/mesosync_phase_select.sv
module mesosync_phase_select #(
  parameter int NPH   = 5,
  parameter int LANES = 4,
  parameter int HW    = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [HW-1:0]          hyst_len,
  input  logic [NPH-1:0]         ref_smp,
  input  logic [LANES*NPH-1:0]   lane_smp,
  output logic [LANES-1:0]       data_out,
  output logic                   data_vld,
  output logic                   slip_drop,
  output logic                   slip_dup,
  output logic                   locked,
  output logic [$clog2(NPH)-1:0] phase_sel
);

  localparam int            PW   = $clog2(NPH);
  localparam logic [PW-1:0] LAST = PW'(NPH - 1);

  if (NPH < 4) begin : g_nph_check
    $error("phase detection needs at least four sampling phases");
  end

  logic          found;
  logic [PW-1:0] idx;
  logic [PW-1:0] sel;
  logic          wrap_drop;
  logic          wrap_dup;

  ps_ref_edge #(.NPH(NPH)) u_edge (
    .ref_smp (ref_smp),
    .found   (found),
    .idx     (idx)
  );

  ps_phase_ctrl #(.NPH(NPH), .HW(HW)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .hyst_len  (hyst_len),
    .found     (found),
    .idx       (idx),
    .sel       (sel),
    .wrap_drop (wrap_drop),
    .wrap_dup  (wrap_dup),
    .locked    (locked)
  );

  ps_lane_pick #(.NPH(NPH), .LANES(LANES)) u_pick (
    .clk      (clk),
    .rst      (rst),
    .lane_smp (lane_smp),
    .sel      (sel),
    .bits_q   (data_out)
  );

  // flags line up with the first word sampled at the new phase
  always_ff @(posedge clk) begin
    if (rst) begin
      data_vld  <= 1'b0;
      slip_drop <= 1'b0;
      slip_dup  <= 1'b0;
    end else begin
      data_vld  <= !wrap_dup;
      slip_drop <= wrap_drop;
      slip_dup  <= wrap_dup;
    end
  end

  assign phase_sel = sel;

  // R7: forward wrap is reported on the next word, which stays valid
  a_r7_drop_flag: assert property (@(posedge clk) disable iff (rst)
    ($past(sel) == LAST && sel == '0) |=> (slip_drop && data_vld));

  // R8: backward wrap is reported on the next word, marked not valid
  a_r8_dup_flag: assert property (@(posedge clk) disable iff (rst)
    ($past(sel) == '0 && sel == LAST) |=> (slip_dup && !data_vld));

  // R8: a repeated word is never valid
  a_r8_dup_invalid: assert property (@(posedge clk) disable iff (rst)
    slip_dup |-> !data_vld && !slip_drop);

endmodule

// File: tb/tb_mesosync_phase_select.sv
`timescale 1ns/1ps
module tb_mesosync_phase_select;

  localparam int NPH   = 5;
  localparam int LANES = 4;
  localparam int HW    = 4;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic [HW-1:0]        hyst_len = '0;
  logic [NPH-1:0]       ref_smp = '0;
  logic [LANES*NPH-1:0] lane_smp = '0;
  logic [LANES-1:0]     data_out;
  logic                 data_vld;
  logic                 slip_drop;
  logic                 slip_dup;
  logic                 locked;
  logic [2:0]           phase_sel;

  int checks = 0;
  int errors = 0;

  localparam logic [19:0] P1 = 20'hA5C3E;
  localparam logic [19:0] P2 = 20'h5A3C1;
  localparam logic [19:0] P3 = 20'h1F0E9;

  always #2 clk = ~clk;

  mesosync_phase_select #(.NPH(NPH), .LANES(LANES), .HW(HW)) dut (
    .clk(clk), .rst(rst), .hyst_len(hyst_len), .ref_smp(ref_smp),
    .lane_smp(lane_smp), .data_out(data_out), .data_vld(data_vld),
    .slip_drop(slip_drop), .slip_dup(slip_dup), .locked(locked),
    .phase_sel(phase_sel)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // reference vector with a single rising edge at index i
  function automatic logic [4:0] rv(input int i);
    return 5'(1 << ((i + 1) % 5));
  endfunction

  function automatic int pick(input logic [19:0] v, input int p);
    logic [3:0] r;
    for (int l = 0; l < 4; l++) r[l] = v[l*5 + p];
    return int'(r);
  endfunction

  task automatic cyc(input logic [4:0] r, input logic [19:0] d);
    ref_smp  = r;
    lane_smp = d;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset(input int h);
    rst      = 1'b1;
    hyst_len = HW'(h);
    ref_smp  = '0;
    lane_smp = '0;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset;
    do_reset(2);
    rst = 1'b1;
    cyc(5'b01010, P1);
    chk("R1", "sel in reset", int'(phase_sel), 0);
    chk("R1", "outputs in reset",
        int'({data_out, data_vld, slip_drop, slip_dup, locked}), 0);
    rst = 1'b0;
    cyc(5'b00000, P1);
    chk("R1", "first sel", int'(phase_sel), 0);
    chk("R1", "first flags", int'({slip_drop, slip_dup, locked}), 0);
  endtask

  task automatic t_data;
    do_reset(2);
    cyc(5'b00000, P1);
    chk("R2", "data phase0 P1", int'(data_out), pick(P1, 0));
    chk("R2", "vld", int'(data_vld), 1);
    cyc(5'b11111, P2);
    chk("R2", "data phase0 P2", int'(data_out), pick(P2, 0));
    cyc(rv(3), P1);
    cyc(rv(3), P2);
    chk("R4", "sel after two fwd requests", int'(phase_sel), 1);
    cyc(5'b00000, P3);
    chk("R2", "data phase1 P3", int'(data_out), pick(P3, 1));
  endtask

  task automatic t_target;
    do_reset(1);
    cyc(5'b00111, P1);             // rise at 4 -> target 2, forward
    chk("R3", "pattern 00111 fwd", int'(phase_sel), 1);
    cyc(5'b11001, P1);             // rise at 2 -> target 0, from 1 backward
    chk("R3", "pattern 11001 bwd", int'(phase_sel), 0);
    cyc(5'b01010, P1);             // rises at 0 and 2, lowest wins -> target 3, bwd
    chk("R3", "pattern 01010 lowest edge", int'(phase_sel), 4);
    cyc(rv(1), P1);                // target 4 equals sel -> none
    chk("R3", "on target no move", int'(phase_sel), 4);
  endtask

  task automatic t_hyst;
    do_reset(2);
    cyc(rv(3), P1);
    chk("R4", "one request only", int'(phase_sel), 0);
    cyc(rv(0), P1);                // opposite direction restarts
    cyc(rv(3), P1);
    chk("R4", "direction change restarts", int'(phase_sel), 0);
    cyc(rv(3), P1);
    chk("R4", "second equal request moves", int'(phase_sel), 1);
    do_reset(2);
    cyc(rv(3), P1);
    cyc(rv(2), P1);                // none request restarts
    cyc(rv(3), P1);
    chk("R4", "none request restarts", int'(phase_sel), 0);
    do_reset(4);
    for (int k = 0; k < 3; k++) cyc(rv(3), P1);
    chk("R4", "hyst 4 after three", int'(phase_sel), 0);
    cyc(rv(3), P1);
    chk("R4", "hyst 4 after four", int'(phase_sel), 1);
  endtask

  task automatic t_step;
    do_reset(0);
    cyc(rv(4), P1);                // target 2 from 0
    chk("R5", "single step first", int'(phase_sel), 1);
    chk("R4", "hyst 0 acts as 1", int'(phase_sel), 1);
    cyc(rv(4), P1);
    chk("R5", "single step second", int'(phase_sel), 2);
    cyc(rv(4), P1);
    chk("R5", "reached target", int'(phase_sel), 2);
  endtask

  task automatic t_quiet;
    do_reset(2);
    cyc(rv(3), P1);
    cyc(5'b00000, P1);
    cyc(5'b11111, P1);
    chk("R6", "quiet keeps sel", int'(phase_sel), 0);
    cyc(rv(3), P1);
    chk("R6", "quiet keeps count", int'(phase_sel), 1);
  endtask

  task automatic t_slip;
    do_reset(1);
    cyc(rv(0), P1);                // target 3, backward wrap 0 -> 4
    chk("R8", "sel wrapped back", int'(phase_sel), 4);
    chk("R8", "no flag yet", int'(slip_dup), 0);
    cyc(5'b00000, P2);
    chk("R8", "dup flag", int'(slip_dup), 1);
    chk("R8", "dup not valid", int'(data_vld), 0);
    chk("R8", "dup word phase4", int'(data_out), pick(P2, 4));
    chk("R8", "no drop on dup", int'(slip_drop), 0);
    cyc(5'b00000, P1);
    chk("R8", "dup one cycle", int'({slip_dup, data_vld}), 1);
    cyc(rv(3), P1);                // target 1 from 4, forward wrap -> 0
    chk("R7", "sel wrapped fwd", int'(phase_sel), 0);
    cyc(5'b00000, P3);
    chk("R7", "drop flag", int'(slip_drop), 1);
    chk("R7", "drop word valid", int'(data_vld), 1);
    chk("R7", "drop word phase0", int'(data_out), pick(P3, 0));
    cyc(5'b00000, P1);
    chk("R7", "drop one cycle", int'(slip_drop), 0);
  endtask

  task automatic t_lock;
    do_reset(2);
    cyc(rv(2), P1);                // target 0 equals sel
    chk("R9", "not yet locked", int'(locked), 0);
    cyc(rv(2), P1);
    chk("R9", "locked after two", int'(locked), 1);
    cyc(5'b00000, P1);
    chk("R6", "quiet keeps lock", int'(locked), 1);
    cyc(rv(0), P1);                // target 3, distance 2
    chk("R9", "far target unlocks", int'(locked), 0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_data();
    t_target();
    t_hyst();
    t_step();
    t_quiet();
    t_slip();
    t_lock();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule